// File: doc/BRIEF.md
# Serial Command Front End

This block is the serial slave input stage of a two-channel wiper controller. An external master lowers chip select and clocks in one 16-bit command word, most significant bit first. Every signal from the master is asynchronous to the system clock. The block runs each one through a multi-flop synchroniser and detects the serial clock edges in the system clock domain. When chip select returns high, the block hands the decoded command code, address and data byte to the execution unit as a registered strobe that lasts one system clock cycle.

The serial output serves two purposes. In a daisy chain, each frame shifts out the contents that the serial register held when the frame began, so the previous word passes on to the next device. After either of the two read commands, the execution unit supplies the selected register byte on `rd_data` during the strobe cycle. That byte replaces the low byte of the serial register, and the master collects it by sending a full 16-clock frame next. While chip select is high the output driver is disabled.

Top module: `serial_cmd_front`

## Requirements
- R1: On each strobe, `cmd_code` equals bits 15:12, `cmd_addr` equals bits 11:8 and `cmd_data` equals bits 7:0 of the last 16 bits shifted in. The first bit shifted is the oldest bit. The fields change only in a cycle where `cmd_valid` is high.
- R2: `cmd_valid` never rises while chip select is low. It goes high once per frame, after chip select returns high, and stays high for exactly one system clock cycle.
- R3: A frame whose code field is 0 (no operation) produces no strobe and leaves `cmd_code`, `cmd_addr` and `cmd_data` unchanged.
- R4: A data bit on `sdi_in` is sampled on each rising edge of `sclk_in` while chip select is low. Bits enter the serial register at bit 0 and move toward bit 15.
- R5: During a frame, `sdo_out` presents bit 15 of the serial register as it stood when the frame began. It advances to the next bit after each falling edge of `sclk_in`. With 16 clocks, the master sampling on rising edges therefore receives the previous serial register contents, most significant bit first.
- R6: When a strobe carries code 9 (read nonvolatile location) or code 10 (read wiper register), the byte on `rd_data` in that strobe cycle replaces bits 7:0 of the serial register. It appears as the last eight output bits of the next 16-clock frame.
- R7: When a frame has fewer or more than 16 clocks, a strobe is still issued. The fields come from the last 16 bits in the serial register, and these include bits kept from earlier frames.
- R8: `sdo_oe` is low while chip select is high and during every strobe. It is high while bits are being transferred.
- R9: Edges on `sclk_in` while chip select is high neither shift the serial register nor cause a strobe.
- R10: After reset, `cmd_valid`, `cmd_code`, `cmd_addr`, `cmd_data`, `sdo_out` and `sdo_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from master, asynchronous |
| csn_in | input | 1 | Chip select, active low, asynchronous |
| sdi_in | input | 1 | Serial data in from master |
| sdo_out | output | 1 | Serial data out (daisy chain / readback) |
| sdo_oe | output | 1 | Output enable for `sdo_out` |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | CODE_W (4) | Command code field |
| cmd_addr | output | ADDR_W (4) | Address field |
| cmd_data | output | DATA_W (8) | Data byte field |
| rd_data | input | DATA_W (8) | Readback byte, valid in the strobe cycle of a read command |

## Verification
The bench builds the block with its default parameters: 4-bit code and address fields, an 8-bit data byte, read codes 9 and 10, and a two-stage synchroniser. It holds each serial clock phase for six system cycles, which leaves enough margin for the synchroniser and edge-detect latency. With these values the bench can test real command codes, including the no-operation code and both read codes. It also covers frames of 12 and 20 clocks, where the captured word keeps bits from the previous frame or drops early bits.

// File: rtl/scf_pkg.sv
// Package: shared types for the serial command front end.
// Assumes: all events are single system-clock pulses in the clk domain.
package scf_pkg;

    // Edge and framing events derived from the synchronised serial pins.
    typedef struct packed {
        logic sample;   // rising serial clock inside a frame
        logic launch;   // falling serial clock inside a frame
        logic open_f;   // chip select has just gone low
        logic close_f;  // chip select has just gone high
    } frame_ev_t;

endpackage

// File: rtl/scf_sync.sv
// Module: scf_sync
// Purpose: a multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes: each bit is independent. Any skew between bits is covered by the
// slow serial protocol, whose bits are held for many system clocks.
module scf_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Purpose: shift the asynchronous pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/scf_framer.sv
// Module: scf_framer
// Purpose: detects serial clock edges and chip-select transitions.
// Assumes: inputs are already synchronised. Clock edges count only inside a
// frame, that is while chip select is low.
module scf_framer
    import scf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_s,
    input  logic      csn_s,
    output frame_ev_t ev
);

    logic sclk_d;
    logic csn_d;

    // Purpose: hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Purpose: form the single-cycle event pulses.
    always_comb begin
        ev.sample  = sclk_s & ~sclk_d & ~csn_s;
        ev.launch  = ~sclk_s & sclk_d & ~csn_s;
        ev.open_f  = ~csn_s & csn_d;
        ev.close_f = csn_s & ~csn_d;
    end

endmodule

// File: rtl/scf_shifter.sv
// Module: scf_shifter
// Purpose: the serial shift register and the serial output stage.
// Assumes: a readback load and a serial sample never occur in the same
// cycle, because loads happen only after a frame has closed. The load still
// takes priority.
module scf_shifter
    import scf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_ev_t         ev,
    input  logic              sdi_s,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    output logic [WORD_W-1:0] word,
    output logic              sdo
);

    // Purpose: shift sampled bits in, or load the readback byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word[DATA_W-1:0] <= ld_data;
        end else if (ev.sample) begin
            word <= {word[WORD_W-2:0], sdi_s};
        end
    end

    // Purpose: drive the output bit at frame open and after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (ev.open_f || ev.launch) begin
            sdo <= word[WORD_W-1];
        end
    end

endmodule

// File: rtl/scf_decode.sv
// Module: scf_decode
// Purpose: splits the captured word into fields and issues the command
// strobe when a frame closes. No-operation frames are suppressed.
// Assumes: the word is stable when the close event fires, because the last
// sample came at least one serial half-period earlier.
module scf_decode #(
    parameter int                 CODE_W  = 4,
    parameter int                 ADDR_W  = 4,
    parameter int                 DATA_W  = 8,
    parameter logic [CODE_W-1:0]  NOP_CODE   = 4'd0,
    parameter logic [CODE_W-1:0]  RD_NV_CODE = 4'd9,
    parameter logic [CODE_W-1:0]  RD_WP_CODE = 4'd10,
    localparam int                WORD_W = CODE_W + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_f,
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              rd_load
);

    logic [CODE_W-1:0] w_code;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;

    // Purpose: slice the captured word into its three fields.
    always_comb begin
        w_code = word[WORD_W-1 -: CODE_W];
        w_addr = word[DATA_W +: ADDR_W];
        w_data = word[DATA_W-1:0];
    end

    // Purpose: register the strobe and fields on frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            code  <= '0;
            addr  <= '0;
            data  <= '0;
        end else if (close_f && (w_code != NOP_CODE)) begin
            valid <= 1'b1;
            code  <= w_code;
            addr  <= w_addr;
            data  <= w_data;
        end else begin
            valid <= 1'b0;
        end
    end

    // Purpose: request the readback load during a read strobe.
    assign rd_load = valid && ((code == RD_NV_CODE) || (code == RD_WP_CODE));

endmodule

// File: rtl/serial_cmd_front.sv
// Module: serial_cmd_front
// Purpose: the serial slave front end. It synchronises the pins, frames the
// command word, strobes decoded fields and drives daisy-chain and readback data.
// Assumes: each serial clock phase lasts several system clocks, more than the
// synchroniser depth plus two.
module serial_cmd_front
    import scf_pkg::*;
#(
    parameter int                CODE_W      = 4,
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [CODE_W-1:0] NOP_CODE    = 4'd0,
    parameter logic [CODE_W-1:0] RD_NV_CODE  = 4'd9,
    parameter logic [CODE_W-1:0] RD_WP_CODE  = 4'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              csn_in,
    input  logic              sdi_in,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int WORD_W = CODE_W + ADDR_W + DATA_W;

    logic       sclk_s;
    logic       csn_s;
    logic       sdi_s;
    frame_ev_t  ev;
    logic       rd_load;
    logic [WORD_W-1:0] ser_word;

    scf_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, csn_in, sdi_in}),
        .q     ({sclk_s, csn_s, sdi_s})
    );

    scf_framer u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .csn_s  (csn_s),
        .ev     (ev)
    );

    scf_shifter #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .sdi_s   (sdi_s),
        .load    (rd_load),
        .ld_data (rd_data),
        .word    (ser_word),
        .sdo     (sdo_out)
    );

    scf_decode #(
        .CODE_W     (CODE_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NOP_CODE   (NOP_CODE),
        .RD_NV_CODE (RD_NV_CODE),
        .RD_WP_CODE (RD_WP_CODE)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .close_f (ev.close_f),
        .word    (ser_word),
        .valid   (cmd_valid),
        .code    (cmd_code),
        .addr    (cmd_addr),
        .data    (cmd_data),
        .rd_load (rd_load)
    );

    // Purpose: enable the output driver only inside a frame.
    assign sdo_oe = ~csn_s;

endmodule

// File: rtl/scf_checker.sv
// Module: scf_checker
// Purpose: temporal checks on the serial command front end, attached by bind.
// Assumes: it observes the top ports and the synchronised chip select and
// serial word inside the top.
module scf_checker #(
    parameter int CODE_W = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int WORD_W = CODE_W + ADDR_W + DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              sdo_oe,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic [WORD_W-1:0] ser_word
);

    // R2: the strobe lasts one cycle.
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: the strobe only appears with chip select high.
    p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> csn_s);

    // R3: no strobe carries the no-operation code.
    p_no_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code != '0));

    // R1: the fields move only together with a strobe.
    p_fields_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable({cmd_code, cmd_addr, cmd_data}));

    // R8: the output driver is off during a strobe.
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !sdo_oe);

    // R9: outside a frame the serial word changes only through a readback load.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_s) && !$past(cmd_valid)) |-> $stable(ser_word));

endmodule

bind serial_cmd_front scf_checker #(
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_scf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (csn_s),
    .sdo_oe    (sdo_oe),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .ser_word  (ser_word)
);

// File: tb/test_serial_cmd_front.sv
module test_serial_cmd_front;

    localparam int HALF = 6;
    localparam int NVEC = 8;
    // Each entry: {clock count[5:0], bits[31:0]}. Bits are sent MSB first from bit count-1.
    localparam logic [37:0] VEC [NVEC] = '{
        {6'd16, 32'h0000B13C},   // write-style code 11
        {6'd16, 32'h00009200},   // read nonvolatile, addr 2
        {6'd16, 32'h00000000},   // no-op, collects readback
        {6'd16, 32'h0000A1FF},   // read wiper, addr 1
        {6'd16, 32'h000035A5},   // collects readback
        {6'd12, 32'h00000C7E},   // short frame
        {6'd20, 32'h0001E219},   // long frame
        {6'd16, 32'h00002055}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0;
    logic       csn_in = 1'b1;
    logic       sdi_in = 1'b0;
    logic       sdo_out;
    logic       sdo_oe;
    logic       cmd_valid;
    logic [3:0] cmd_code;
    logic [3:0] cmd_addr;
    logic [7:0] cmd_data;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    int strobe_cnt = 0;
    bit done = 0;
    logic [15:0] model = 16'h0000;
    bit prev_read = 0;

    always #10 clk = ~clk;

    // Readback byte supplied by a modelled execution unit.
    function automatic logic [7:0] rd_model(input logic [3:0] c, input logic [3:0] a);
        return (c == 4'd9) ? ({a, ~a} ^ 8'h5A) : {a, ~a};
    endfunction

    assign rd_data = rd_model(cmd_code, cmd_addr);

    serial_cmd_front i_serial_cmd_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .csn_in    (csn_in),
        .sdi_in    (sdi_in),
        .sdo_out   (sdo_out),
        .sdo_oe    (sdo_oe),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_data   (rd_data)
    );

    always @(negedge clk) if (cmd_valid) strobe_cnt <= strobe_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_vec(input logic [31:0] bits, input int n, input string stag);
        logic [15:0] m;
        logic [15:0] got;
        logic [15:0] exp;
        logic [3:0]  pc, pa;
        logic [7:0]  pd;
        bit oe_bad;
        string tag;
        m = model;
        got = '0;
        exp = '0;
        oe_bad = 0;
        pc = cmd_code; pa = cmd_addr; pd = cmd_data;
        strobe_cnt = 0;
        csn_in = 1'b0;
        for (int k = 0; k < n; k++) begin
            sdi_in = bits[n-1-k];
            wait_clk(HALF);
            if (k < 16) begin
                got = {got[14:0], sdo_out};
                exp = {exp[14:0], m[15]};
            end
            if (!sdo_oe) oe_bad = 1;
            sclk_in = 1'b1;
            m = {m[14:0], bits[n-1-k]};
            wait_clk(HALF);
            sclk_in = 1'b0;
        end
        wait_clk(HALF);
        check(strobe_cnt == 0, "R2 no strobe inside frame", strobe_cnt, 0);
        check(!oe_bad, "R8 output enabled in frame", {31'd0, oe_bad}, 0);
        csn_in = 1'b1;
        wait_clk(12);
        check(sdo_oe == 1'b0, "R8 output disabled after frame", {31'd0, sdo_oe}, 0);
        if (m[15:12] == 4'd0) begin
            check(strobe_cnt == 0, "R3 no-op gives no strobe", strobe_cnt, 0);
            check({cmd_code, cmd_addr, cmd_data} == {pc, pa, pd}, "R3 fields unchanged",
                  {16'd0, cmd_code, cmd_addr, cmd_data}, {16'd0, pc, pa, pd});
        end else begin
            check(strobe_cnt == 1, "R2 single one-cycle strobe", strobe_cnt, 1);
            tag = (n != 16) ? "R7 fields from last 16 bits" : "R1 R4 field layout";
            check({cmd_code, cmd_addr, cmd_data} == m, tag,
                  {16'd0, cmd_code, cmd_addr, cmd_data}, {16'd0, m});
        end
        if (stag.len() != 0) tag = stag;
        else if (prev_read && n == 16) tag = "R6 readback byte on output";
        else tag = "R5 output stream";
        if (n < 16) begin
            got = got & ((16'h1 << n) - 16'h1);
            exp = exp & ((16'h1 << n) - 16'h1);
        end
        check(got == exp, tag, {16'd0, got}, {16'd0, exp});
        prev_read = (m[15:12] == 4'd9) || (m[15:12] == 4'd10);
        if (prev_read) m[7:0] = rd_model(m[15:12], m[11:8]);
        model = m;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R10: reset state
        check({cmd_valid, cmd_code, cmd_addr, cmd_data, sdo_out, sdo_oe} == '0,
              "R10 reset outputs zero",
              {13'd0, cmd_valid, cmd_code, cmd_addr, cmd_data, sdo_out, sdo_oe}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][31:0], int'(VEC[v][37:32]), "");
        end

        // R9: serial clock edges with chip select high are ignored
        strobe_cnt = 0;
        for (int t = 0; t < 10; t++) begin
            sdi_in = 1'b1;
            sclk_in = 1'b1;
            wait_clk(HALF);
            sclk_in = 1'b0;
            wait_clk(HALF);
            check(sdo_oe == 1'b0, "R9 driver stays off while idle", {31'd0, sdo_oe}, 0);
        end
        check(strobe_cnt == 0, "R9 no strobe from idle clocks", strobe_cnt, 0);
        run_vec(32'h00000000, 16, "R9 serial word untouched by idle clocks");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule